// File: doc/BRIEF.md
# Relative branch target and condition unit

This unit forms the next program counter for a small coprocessor whose instructions are all 16 bits wide. Each cycle it takes the current PC, the offset field from the instruction, the branch kind, a condition selector and the four arithmetic flags. It produces the address that instruction fetch uses next. Branch targets are measured from the instruction after the branch. The signed word offset is scaled by two to give a byte address.

Conditional branches carry a 9-bit signed word offset, which reaches from -256 to +255 words. Unconditional branches carry a 10-bit offset, which reaches from -512 to +511 words. A conditional branch tests one of fourteen conditions built from N, Z, V and C. If the test fails, the unit falls through to the sequential address. The result is registered, so the next PC appears one clock after the inputs.

Top module: `brcc_next_pc`

## Requirements
- R1: While rst_ni is low, pc_next_o is 0.
- R2: pc_next_o shows the result for the inputs sampled at the previous rising clock edge.
- R3: When kind_i is 0 (no branch) or 3 (reserved), pc_next_o = pc_i + 2. Here pc_i is taken with bit 0 cleared.
- R4: When kind_i is 2 (unconditional), pc_next_o = pc_i + 2 + 2 * sign_extend(off_i[9:0]). This covers offsets from -512 to +511 words.
- R5: When kind_i is 1 (conditional) and the condition holds, pc_next_o = pc_i + 2 + 2 * sign_extend(off_i[8:0]). This covers offsets from -256 to +255 words, and off_i[9] has no effect.
- R6: When kind_i is 1 and the condition fails, pc_next_o = pc_i + 2.
- R7: cond_i selects the condition. flags_i is {N,Z,V,C} from bit 3 down to bit 0. The codes are:
  - 0: C=0
  - 1: C=1
  - 2: Z=0
  - 3: Z=1
  - 4: N=0
  - 5: N=1
  - 6: V=0
  - 7: V=1
  - 8: unsigned higher, C=0 and Z=0
  - 9: unsigned lower or same, C=1 or Z=1
  - 10: N=V
  - 11: N!=V
  - 12: Z=0 and N=V
  - 13: Z=1 or N!=V
  - 14 and 15: never true
- R8: Bit 0 of pc_i has no effect, and bit 0 of pc_next_o is always 0.
- R9: All address arithmetic wraps modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pc_i | input | 16 | Address of the current instruction |
| off_i | input | 10 | Signed word offset field from the instruction |
| kind_i | input | 2 | 0 none, 1 conditional, 2 unconditional, 3 reserved |
| cond_i | input | 4 | Condition selector for conditional branches |
| flags_i | input | 4 | Flags {N,Z,V,C} |
| pc_next_o | output | 16 | Registered next program counter |

## Verification
The bench drives branches with the largest forward and backward offsets of both kinds. A unit that sign-extends the wrong bit, or scales by the wrong amount, would land up to 1 KiB away from the expected target. The bench sets off_i[9] on conditional branches; a unit that used the 10-bit field for them would jump backward instead of forward. Targets that cross 0xFFFE and 0x0000 expose an adder that saturates or carries into a wider result. The bench also walks every condition code across all sixteen flag patterns, which catches swapped signed and unsigned comparisons or an inverted sense.

// File: rtl/brcc_pkg.sv
package brcc_pkg;
  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_COND = 2'd1,
    KIND_JUMP = 2'd2,
    KIND_RSVD = 2'd3
  } br_kind_e;

  typedef enum logic [3:0] {
    CC_CCLR = 4'd0,  CC_CSET = 4'd1,  CC_NE = 4'd2,  CC_EQ = 4'd3,
    CC_PL   = 4'd4,  CC_MI   = 4'd5,  CC_VC = 4'd6,  CC_VS = 4'd7,
    CC_HI   = 4'd8,  CC_LS   = 4'd9,  CC_GE = 4'd10, CC_LT = 4'd11,
    CC_GT   = 4'd12, CC_LE   = 4'd13, CC_N0 = 4'd14, CC_N1 = 4'd15
  } br_cond_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;
endpackage

// File: rtl/brcc_cond_eval.sv
module brcc_cond_eval
  import brcc_pkg::*;
(
  input  logic [3:0] cond_i,
  input  flags_t     flags_i,
  output logic       taken_o
);
  logic lt;
  assign lt = flags_i.n ^ flags_i.v;

  always_comb begin
    unique case (br_cond_e'(cond_i))
      CC_CCLR: taken_o = ~flags_i.c;
      CC_CSET: taken_o = flags_i.c;
      CC_NE:   taken_o = ~flags_i.z;
      CC_EQ:   taken_o = flags_i.z;
      CC_PL:   taken_o = ~flags_i.n;
      CC_MI:   taken_o = flags_i.n;
      CC_VC:   taken_o = ~flags_i.v;
      CC_VS:   taken_o = flags_i.v;
      CC_HI:   taken_o = ~(flags_i.c | flags_i.z);
      CC_LS:   taken_o = flags_i.c | flags_i.z;
      CC_GE:   taken_o = ~lt;
      CC_LT:   taken_o = lt;
      CC_GT:   taken_o = ~(flags_i.z | lt);
      CC_LE:   taken_o = flags_i.z | lt;
      default: taken_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/brcc_target_calc.sv
module brcc_target_calc #(
  parameter int PC_W       = 16,
  parameter int OFF_W      = 10,
  parameter int USED_W     = 9,
  parameter int INSN_BYTES = 2
) (
  input  logic [PC_W-1:0]  seq_i,
  input  logic [OFF_W-1:0] off_i,
  output logic [PC_W-1:0]  tgt_o
);
  localparam int SHIFT = $clog2(INSN_BYTES);
  localparam int EXT_W = PC_W - USED_W;

  logic [PC_W-1:0] disp;

  generate
    if (EXT_W > 0) begin : g_ext
      assign disp = {{EXT_W{off_i[USED_W-1]}}, off_i[USED_W-1:0]} << SHIFT;
    end else begin : g_trunc
      assign disp = off_i[PC_W-1:0] << SHIFT;
    end
  endgenerate

  assign tgt_o = seq_i + disp;
endmodule

// File: rtl/brcc_next_pc.sv
module brcc_next_pc
  import brcc_pkg::*;
#(
  parameter int PC_W       = 16,
  parameter int COND_W     = 9,
  parameter int JUMP_W     = 10,
  parameter int INSN_BYTES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [JUMP_W-1:0] off_i,
  input  logic [1:0]        kind_i,
  input  logic [3:0]        cond_i,
  input  logic [3:0]        flags_i,
  output logic [PC_W-1:0]   pc_next_o
);
  localparam int ALIGN = $clog2(INSN_BYTES);

  logic [PC_W-1:0] pc_al, seq, tgt_cond, tgt_jump;
  logic [PC_W-1:0] next_d;
  logic            cond_ok;

  assign pc_al = {pc_i[PC_W-1:ALIGN], {ALIGN{1'b0}}};
  assign seq   = pc_al + PC_W'(INSN_BYTES);

  brcc_cond_eval u_cond (
    .cond_i  (cond_i),
    .flags_i (flags_t'(flags_i)),
    .taken_o (cond_ok)
  );

  brcc_target_calc #(
    .PC_W(PC_W), .OFF_W(JUMP_W), .USED_W(COND_W), .INSN_BYTES(INSN_BYTES)
  ) u_tgt_cond (
    .seq_i(seq), .off_i(off_i), .tgt_o(tgt_cond)
  );

  brcc_target_calc #(
    .PC_W(PC_W), .OFF_W(JUMP_W), .USED_W(JUMP_W), .INSN_BYTES(INSN_BYTES)
  ) u_tgt_jump (
    .seq_i(seq), .off_i(off_i), .tgt_o(tgt_jump)
  );

  always_comb begin
    unique case (br_kind_e'(kind_i))
      KIND_COND: next_d = cond_ok ? tgt_cond : seq;
      KIND_JUMP: next_d = tgt_jump;
      default:   next_d = seq;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_next_o <= '0;
    else         pc_next_o <= next_d;
  end

  AST_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_next_o[0] == 1'b0); // R8

  AST_SEQ_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == 2'd0 || kind_i == 2'd3) |=>
      pc_next_o == PC_W'({$past(pc_i[PC_W-1:1]), 1'b0} + 2)); // R3

  AST_EQ_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == 2'd1 && cond_i == 4'd3 && flags_i[2] && off_i[8:0] != 9'd0) |=>
      pc_next_o != PC_W'({$past(pc_i[PC_W-1:1]), 1'b0} + 2)); // R7

  AST_NEVER_COND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == 2'd1 && cond_i[3:1] == 3'b111) |=>
      pc_next_o == PC_W'({$past(pc_i[PC_W-1:1]), 1'b0} + 2)); // R6

  AST_JUMP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == 2'd2 && off_i == '0) |=>
      pc_next_o == PC_W'({$past(pc_i[PC_W-1:1]), 1'b0} + 2)); // R4
endmodule

// File: tb/brcc_next_pc_test.sv
module brcc_next_pc_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] pc_i = '0;
  logic [9:0]  off_i = '0;
  logic [1:0]  kind_i = '0;
  logic [3:0]  cond_i = '0;
  logic [3:0]  flags_i = '0;
  logic [15:0] pc_next_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  brcc_next_pc uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .pc_i(pc_i), .off_i(off_i),
    .kind_i(kind_i), .cond_i(cond_i), .flags_i(flags_i), .pc_next_o(pc_next_o)
  );

  function automatic bit cond_true(input logic [3:0] c, input logic [3:0] f);
    bit n, z, v, cy;
    {n, z, v, cy} = f;
    case (c)
      4'd0:  return !cy;
      4'd1:  return cy;
      4'd2:  return !z;
      4'd3:  return z;
      4'd4:  return !n;
      4'd5:  return n;
      4'd6:  return !v;
      4'd7:  return v;
      4'd8:  return !cy && !z;
      4'd9:  return cy || z;
      4'd10: return n == v;
      4'd11: return n != v;
      4'd12: return !z && (n == v);
      4'd13: return z || (n != v);
      default: return 0;
    endcase
  endfunction

  function automatic logic [15:0] ref_pc(input logic [15:0] pc, input logic [9:0] off,
                                         input logic [1:0] k, input logic [3:0] c,
                                         input logic [3:0] f);
    int base, d;
    base = (pc & 16'hFFFE) + 2;
    if (k == 2'd2) begin
      d = off[9] ? int'(off) - 1024 : int'(off);
      return 16'(base + 2 * d);
    end
    if (k == 2'd1 && cond_true(c, f)) begin
      d = off[8] ? int'(off[8:0]) - 512 : int'(off[8:0]);
      return 16'(base + 2 * d);
    end
    return 16'(base);
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input string req, input logic [15:0] pc, input logic [9:0] off,
                       input logic [1:0] k, input logic [3:0] c, input logic [3:0] f);
    logic [15:0] exp;
    @(negedge clk_i);
    pc_i = pc; off_i = off; kind_i = k; cond_i = c; flags_i = f;
    exp = ref_pc(pc, off, k, c, f);
    @(posedge clk_i);
    #2;
    check(req, pc_next_o, exp);
    if (pc_next_o[0] !== 1'b0) check("R8 bit0", pc_next_o, pc_next_o & 16'hFFFE);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    pc_i = 16'h1234; off_i = 10'h155; kind_i = 2'd2;
    repeat (3) @(posedge clk_i);
    #2;
    check("R1 reset", pc_next_o, 16'h0000);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R2 R3: sequential kinds
    apply("R3 none", 16'h1000, 10'h3FF, 2'd0, 4'd3, 4'hF);
    apply("R3 reserved", 16'h2002, 10'h001, 2'd3, 4'd3, 4'hF);
    apply("R2 next cycle", 16'h0040, 10'h000, 2'd0, 4'd0, 4'h0);
    // R4 extremes
    apply("R4 max fwd", 16'h4000, 10'h1FF, 2'd2, 4'd0, 4'h0);
    apply("R4 max back", 16'h4000, 10'h200, 2'd2, 4'd0, 4'h0);
    // R5 extremes and bit 9 ignored
    apply("R5 max fwd", 16'h4000, 10'h0FF, 2'd1, 4'd3, 4'h4);
    apply("R5 max back", 16'h4000, 10'h100, 2'd1, 4'd3, 4'h4);
    apply("R5 bit9 ignored", 16'h4000, 10'h20F, 2'd1, 4'd3, 4'h4);
    // R6 not taken
    apply("R6 eq not taken", 16'h4000, 10'h0FF, 2'd1, 4'd3, 4'h0);
    apply("R6 never code", 16'h4000, 10'h0FF, 2'd1, 4'd15, 4'hF);
    // R8 odd pc
    apply("R8 odd pc", 16'h3001, 10'h004, 2'd2, 4'd0, 4'h0);
    // R9 wraparound
    apply("R9 wrap seq", 16'hFFFE, 10'h000, 2'd0, 4'd0, 4'h0);
    apply("R9 wrap fwd", 16'hFF00, 10'h1FF, 2'd2, 4'd0, 4'h0);
    apply("R9 wrap back", 16'h0010, 10'h200, 2'd2, 4'd0, 4'h0);
    apply("R9 wrap cond", 16'h0000, 10'h100, 2'd1, 4'd2, 4'h0);

    // R7 every code against every flag pattern
    for (int c = 0; c < 16; c++)
      for (int f = 0; f < 16; f++)
        apply("R7 cond table", 16'h8000, 10'h010, 2'd1, 4'(c), 4'(f));

    // random mix covering R3 R4 R5 R6
    for (int i = 0; i < 400; i++)
      apply("R5 random", 16'($urandom), 10'($urandom), 2'($urandom),
            4'($urandom), 4'($urandom));

    // R1 asynchronous reset mid-run
    @(negedge clk_i);
    rst_ni = 1'b0;
    #2;
    check("R1 async reset", pc_next_o, 16'h0000);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule